// File: doc/BRIEF.md
# Priority-Resolved Active Address Output

This block produces the page:address output of one device in a chain of associative memory devices. Each completed cycle reported by the cycle decoder names a source for the active address. A compare selects the match address, a write into the next free slot selects the free address, and a random read or write selects the accessed address. The chosen address is joined with the device's page number to form the bus value.

The value is only allowed to move while chip enable is high. A cycle that completes while chip enable is low is held pending and takes effect at the first clock edge at which chip enable is high. The match flag that feeds the priority chain follows the same rule.

Devices are chained through active-low match signals running from higher to lower priority. After a compare, with output enable low, only the highest-priority device that matched drives the bus. When no device in the chain matched, the device marked as lowest priority drives all ones. Every other device leaves the bus at high impedance.

Top module: `aa_out_port`

## Requirements
- R1: After a committed compare with `cmp_hit`=1, `oe_n`=0 and `mi_n`=1, `bus_pins` equals {`page_id`, `match_addr`} with the page in the upper bits.
- R2: After a committed next-free cycle (`cyc_kind`=2), the driven value is {`page_id`, `free_addr`} whenever `oe_n`=0.
- R3: After a committed random read or write (`cyc_kind`=3), the driven value is {`page_id`, `rand_addr`} whenever `oe_n`=0.
- R4: A cycle reported (`cyc_done`=1) while `ce_n`=1 commits at that clock edge. A cycle reported while `ce_n`=0 leaves the output value unchanged and commits at the first edge with `ce_n`=1.
- R5: With `oe_n`=1, `bus_drive` is 0 and `bus_pins` is all Z.
- R6: After a compare with `mi_n`=0, the device does not drive, even if it matched and `oe_n`=0.
- R7: `mo_n` is 0 exactly when `mi_n` is 0 or the last committed cycle was a compare (`cyc_kind`=1) with a hit.
- R8: After a committed compare without a hit, with `mi_n`=1 and `oe_n`=0, a device with `last_dev`=1 drives all ones and a device with `last_dev`=0 stays Z.
- R9: The match result of a compare reported while `ce_n`=0 does not reach `mo_n` until an edge with `ce_n`=1.
- R10: After reset the device drives nothing and `mo_n` equals `mi_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; the output is frozen while it is low |
| oe_n | input | 1 | Output enable, active low |
| cyc_done | input | 1 | One-cycle pulse: a cycle completed |
| cyc_kind | input | 2 | Cycle type: 1 compare, 2 next-free write, 3 random access |
| cmp_hit | input | 1 | The compare matched in this device |
| match_addr | input | AW | Highest-priority matching location |
| free_addr | input | AW | Next free location |
| rand_addr | input | AW | Randomly accessed location |
| page_id | input | PW | Page number of this device |
| last_dev | input | 1 | This device is lowest priority in the chain |
| mi_n | input | 1 | Match-in from the higher-priority neighbour, active low |
| mo_n | output | 1 | Match-out to the lower-priority neighbour, active low |
| bus_drive | output | 1 | This device is driving the bus |
| bus_pins | output | PW+AW | Tri-state page:address bus |

## Verification
On every cycle the assertions check that the held address does not move while chip enable is low, that a high output enable never lets the device drive, that match-out follows match-in, and that a device never drives a compare result with match-in asserted. Only the bench scenarios show that the correct source is chosen for each cycle type, that a pending cycle lands at the first edge with chip enable high, and that the all-ones default appears only on the lowest-priority device.

// File: rtl/aa_out_pkg.sv
// Shared types for the active address output block.
package aa_out_pkg;
    // Source of the active address, taken from the last committed cycle.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CMP  = 2'd1,
        SRC_FREE = 2'd2,
        SRC_RAND = 2'd3
    } aa_src_e;
endpackage

// File: rtl/aa_src_latch.sv
// Picks the active address for each completed cycle and holds it. The new
// value commits only at an edge where chip enable (ce_n) is high. A cycle
// that completes while ce_n is low waits in a pending slot. Assumes cyc_done
// is a one-cycle pulse from the cycle decoder.
module aa_src_latch
    import aa_out_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          cyc_done,
    input  aa_src_e       cyc_kind,
    input  logic          cmp_hit,
    input  logic [AW-1:0] match_addr,
    input  logic [AW-1:0] free_addr,
    input  logic [AW-1:0] rand_addr,
    output aa_src_e       act_kind,
    output logic          act_hit,
    output logic [AW-1:0] act_addr
);
    logic          pend_v;
    aa_src_e       pend_kind;
    logic          pend_hit;
    logic [AW-1:0] pend_addr;

    logic [AW-1:0] new_addr;
    aa_src_e       cand_kind;
    logic          cand_hit;
    logic [AW-1:0] cand_addr;
    logic          cand_v;

    // Address chosen by the cycle type being reported now.
    always_comb begin
        unique case (cyc_kind)
            SRC_CMP:  new_addr = match_addr;
            SRC_FREE: new_addr = free_addr;
            SRC_RAND: new_addr = rand_addr;
            default:  new_addr = '0;
        endcase
    end

    // The candidate for commit: a fresh cycle wins over a pending one.
    always_comb begin
        cand_v    = cyc_done || pend_v;
        cand_kind = cyc_done ? cyc_kind : pend_kind;
        cand_hit  = cyc_done ? (cmp_hit && cyc_kind == SRC_CMP) : pend_hit;
        cand_addr = cyc_done ? new_addr : pend_addr;
    end

    // Pending slot: holds a cycle that completed while ce_n was low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_kind <= SRC_NONE;
            pend_hit  <= 1'b0;
            pend_addr <= '0;
        end else if (ce_n) begin
            pend_v <= 1'b0;
        end else if (cyc_done) begin
            pend_v    <= 1'b1;
            pend_kind <= cyc_kind;
            pend_hit  <= cmp_hit && cyc_kind == SRC_CMP;
            pend_addr <= new_addr;
        end
    end

    // Active registers: take the candidate only while ce_n is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_kind <= SRC_NONE;
            act_hit  <= 1'b0;
            act_addr <= '0;
        end else if (ce_n && cand_v) begin
            act_kind <= cand_kind;
            act_hit  <= cand_hit;
            act_addr <= cand_addr;
        end
    end

    // R4 / R9: the held address and match flag stay frozen across an edge with ce_n low.
    assert_hold_when_ce_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n == 1'b0 |=> ($stable(act_addr) && $stable(act_hit) && $stable(act_kind)));

    // A hit is only ever recorded for a compare.
    assert_hit_only_on_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |-> act_kind == SRC_CMP);
endmodule

// File: rtl/aa_chain_ctl.sv
// Resolves priority along the match daisy chain and decides whether this
// device drives the shared bus, and with which value. Assumes mi_n is high
// when no higher-priority device matched.
module aa_chain_ctl
    import aa_out_pkg::*;
#(
    parameter int AW = 10,
    parameter int PW = 4,
    localparam int BW = PW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          oe_n,
    input  logic          mi_n,
    input  logic          last_dev,
    input  logic [PW-1:0] page_id,
    input  aa_src_e       act_kind,
    input  logic          act_hit,
    input  logic [AW-1:0] act_addr,
    output logic          mo_n,
    output logic          drive,
    output logic [BW-1:0] drive_val
);
    logic is_cmp;
    logic win;
    logic miss_default;

    // Classify the committed state for the priority decision.
    always_comb begin
        is_cmp       = (act_kind == SRC_CMP);
        win          = is_cmp && act_hit && mi_n;
        miss_default = is_cmp && !act_hit && mi_n && last_dev;
    end

    // Match-out: pass a higher-priority match along, or announce our own.
    always_comb begin
        mo_n = mi_n && !(is_cmp && act_hit);
    end

    // Drive decision and the value to place on the bus.
    always_comb begin
        drive     = 1'b0;
        drive_val = {page_id, act_addr};
        if (!oe_n) begin
            if (act_kind == SRC_FREE || act_kind == SRC_RAND) begin
                drive = 1'b1;
            end else if (win) begin
                drive = 1'b1;
            end else if (miss_default) begin
                drive     = 1'b1;
                drive_val = '1;
            end
        end
    end

    // R7: a match from upstream always propagates downstream.
    assert_mo_follows_mi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mi_n |-> !mo_n);

    // R6: a compare result is never driven while a higher device claims the bus.
    assert_no_drive_below_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && act_kind == SRC_CMP) |-> mi_n);
endmodule

// File: rtl/aa_out_port.sv
// Active address output port for one device in a chain of associative
// memory devices. It holds the page:address of the last cycle and places it
// on a tri-state bus under output enable and daisy-chain priority. Assumes
// the cycle decoder reports each completed cycle with a one-cycle cyc_done.
module aa_out_port
    import aa_out_pkg::*;
#(
    parameter int AW = 10,
    parameter int PW = 4,
    localparam int BW = PW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          cyc_done,
    input  logic [1:0]    cyc_kind,
    input  logic          cmp_hit,
    input  logic [AW-1:0] match_addr,
    input  logic [AW-1:0] free_addr,
    input  logic [AW-1:0] rand_addr,
    input  logic [PW-1:0] page_id,
    input  logic          last_dev,
    input  logic          mi_n,
    output logic          mo_n,
    output logic          bus_drive,
    output wire  [BW-1:0] bus_pins
);
    aa_src_e       act_kind;
    logic          act_hit;
    logic [AW-1:0] act_addr;
    logic [BW-1:0] drive_val;

    aa_src_latch #(.AW(AW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .cyc_done   (cyc_done),
        .cyc_kind   (aa_src_e'(cyc_kind)),
        .cmp_hit    (cmp_hit),
        .match_addr (match_addr),
        .free_addr  (free_addr),
        .rand_addr  (rand_addr),
        .act_kind   (act_kind),
        .act_hit    (act_hit),
        .act_addr   (act_addr)
    );

    aa_chain_ctl #(.AW(AW), .PW(PW)) u_chain (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n      (oe_n),
        .mi_n      (mi_n),
        .last_dev  (last_dev),
        .page_id   (page_id),
        .act_kind  (act_kind),
        .act_hit   (act_hit),
        .act_addr  (act_addr),
        .mo_n      (mo_n),
        .drive     (bus_drive),
        .drive_val (drive_val)
    );

    // Tri-state pins: high impedance unless this device owns the bus.
    assign bus_pins = bus_drive ? drive_val : {BW{1'bz}};

    // R5: output enable high keeps the device off the bus.
    assert_oe_high_no_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !bus_drive);

    // R10: the cycle after reset the device is idle.
    assert_idle_after_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (!bus_drive && mo_n == mi_n));
endmodule

// File: tb/aa_out_port_test.sv
// Directed bench for aa_out_port: one task per scenario.
module aa_out_port_test;
    localparam int AW = 10;
    localparam int PW = 4;
    localparam int BW = PW + AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          cyc_done = 1'b0;
    logic [1:0]    cyc_kind = 2'd0;
    logic          cmp_hit = 1'b0;
    logic [AW-1:0] match_addr = '0;
    logic [AW-1:0] free_addr = '0;
    logic [AW-1:0] rand_addr = '0;
    logic [PW-1:0] page_id = 4'hA;
    logic          last_dev = 1'b0;
    logic          mi_n = 1'b1;
    wire           mo_n;
    wire           bus_drive;
    wire  [BW-1:0] bus_pins;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [BW-1:0] ZZ = {BW{1'bz}};

    aa_out_port #(.AW(AW), .PW(PW)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .cyc_done(cyc_done), .cyc_kind(cyc_kind), .cmp_hit(cmp_hit),
        .match_addr(match_addr), .free_addr(free_addr), .rand_addr(rand_addr),
        .page_id(page_id), .last_dev(last_dev), .mi_n(mi_n),
        .mo_n(mo_n), .bus_drive(bus_drive), .bus_pins(bus_pins)
    );

    always #10 clk = ~clk;

    task automatic chk_bus(input string req, input logic [BW-1:0] exp);
        n_chk++;
        if (bus_pins !== exp) begin
            n_err++;
            $display("FAIL %s: bus_pins got %h expected %h", req, bus_pins, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: %s got %b expected %b", req, what, got, exp);
        end
    endtask

    // Report one cycle on the decoder pins, then let settle after the edge.
    task automatic run_cycle(input logic [1:0] kind, input logic hit, input logic ce);
        @(negedge clk);
        ce_n = ce; cyc_done = 1'b1; cyc_kind = kind; cmp_hit = hit;
        @(negedge clk);
        cyc_done = 1'b0; cyc_kind = 2'd0; cmp_hit = 1'b0;
    endtask

    task automatic t_reset;
        chk_bus("R10", ZZ);
        chk_bit("R10", "bus_drive", bus_drive, 1'b0);
        chk_bit("R10", "mo_n", mo_n, 1'b1);
        oe_n = 1'b0; #1;
        chk_bus("R10", ZZ);
    endtask

    task automatic t_compare_winner;
        match_addr = 10'h155; mi_n = 1'b1; oe_n = 1'b0;
        run_cycle(2'd1, 1'b1, 1'b1);
        chk_bus("R1", {4'hA, 10'h155});
        chk_bit("R7", "mo_n", mo_n, 1'b0);
        mi_n = 1'b0; #1;
        chk_bus("R6", ZZ);
        chk_bit("R7", "mo_n", mo_n, 1'b0);
        mi_n = 1'b1; oe_n = 1'b1; #1;
        chk_bus("R5", ZZ);
        chk_bit("R5", "bus_drive", bus_drive, 1'b0);
    endtask

    task automatic t_free_held;
        oe_n = 1'b0; free_addr = 10'h0F3;
        run_cycle(2'd2, 1'b0, 1'b0);
        @(negedge clk);
        chk_bus("R4", {4'hA, 10'h155});
        ce_n = 1'b1;
        @(negedge clk);
        chk_bus("R2", {4'hA, 10'h0F3});
        chk_bit("R7", "mo_n", mo_n, 1'b1);
    endtask

    task automatic t_random;
        rand_addr = 10'h2C8; page_id = 4'h5;
        run_cycle(2'd3, 1'b0, 1'b1);
        chk_bus("R3", {4'h5, 10'h2C8});
        oe_n = 1'b1; #1;
        chk_bus("R5", ZZ);
        oe_n = 1'b0; page_id = 4'hA;
    endtask

    task automatic t_miss_default;
        match_addr = 10'h011; last_dev = 1'b0;
        run_cycle(2'd1, 1'b0, 1'b1);
        chk_bus("R8", ZZ);
        chk_bit("R7", "mo_n", mo_n, 1'b1);
        last_dev = 1'b1; #1;
        chk_bus("R8", {BW{1'b1}});
        mi_n = 1'b0; #1;
        chk_bus("R8", ZZ);
        chk_bit("R7", "mo_n", mo_n, 1'b0);
        mi_n = 1'b1; last_dev = 1'b0;
    endtask

    task automatic t_flag_deferred;
        match_addr = 10'h3A0;
        run_cycle(2'd1, 1'b1, 1'b0);
        chk_bit("R9", "mo_n", mo_n, 1'b1);
        chk_bus("R9", ZZ);
        ce_n = 1'b1;
        @(negedge clk);
        chk_bit("R9", "mo_n", mo_n, 1'b0);
        chk_bus("R9", {4'hA, 10'h3A0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_compare_winner();
        t_free_held();
        t_random();
        t_miss_default();
        t_flag_deferred();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule